// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block reads a table of 8-byte scatter-gather descriptors from system memory and turns it into a stream of burst transfer commands for a disk-side data buffer. Software sets the table base and pulses `start`. After that, the device side offers buffers one at a time as a byte count plus a direction. For each buffer the walker issues commands. Each command covers as much of the buffer as the current descriptor still has room for. The walker fetches the next descriptor only when the current one is used up.

The walker keeps the current descriptor's address, remaining length and last-entry flag from one buffer to the next. Space left over at the end of one buffer therefore serves the next one. The walk ends in two cases: the bytes are needed but the last descriptor is used up, or the table pointer has gone one page past the base. The walker then raises a table-end flag and pulses `underrun`. A separate `page_limit` flag tells a page-limit stop apart from a stop at the last entry.

The buffer, descriptor-fetch and command interfaces all use valid/ready. A source holds valid and its payload stable until ready is seen at a clock edge. The walker holds `rd_req_valid`/`rd_addr` and `xfer_valid`/`xfer_addr`/`xfer_len`/`xfer_dir` stable while the sink stalls. Fetch responses have no ready: the memory side must present `rd_rsp_valid` for one cycle per accepted request.

Top module: `sg_table_walker`

## Requirements
- R1: Synchronous reset clears every pointer, length, flag and pulse. After reset, `walk_active`, `buf_ready`, `rd_req_valid`, `xfer_valid`, `tbl_end` and `page_limit` are all 0.
- R2: A descriptor is one 64-bit response word. Bits [31:0] hold the buffer address and bits [63:32] hold the size/flags word. The first fetch reads the table base, and each accepted fetch advances the table pointer by 8.
- R3: The transfer length of a descriptor is size bits [15:0] with bit 0 forced to 0, so every command length is even and non-zero.
- R4: A masked length of 0 means 65536 bytes.
- R5: Size bit 31 marks the final descriptor. Once that descriptor's length is used up and more bytes are needed, no further fetch is made, `tbl_end` goes to 1 and `page_limit` stays 0.
- R6: A descriptor is fetched only when the remaining length of the current one is 0. At most one fetch is outstanding at any time.
- R7: Each command length is the smaller of the buffer's pending bytes and the descriptor's remaining length. The descriptor address then rises, and both counts fall, by that length. Leftover descriptor space carries over to the next buffer.
- R8: When a buffer's pending bytes reach 0, `buf_done` pulses for one cycle and `buf_ready` returns to 1. A buffer of 0 bytes completes at once.
- R9: No fetch is made once the table pointer is 4096 or more bytes past the base. A stop for this reason sets `page_limit` and `tbl_end`.
- R10: When the table ends while buffer bytes are pending, `underrun` pulses for one cycle and `walk_active` returns to 0.
- R11: `start` loads the base and table pointer, clears the descriptor state and both end flags, and takes priority over `abort`. `abort` returns the walker to idle. A fetch response still owed at `start` or `abort` is discarded.
- R12: While `xfer_valid` is high and `xfer_ready` is low, the command fields hold stable. While `rd_req_valid` is high and `rd_req_ready` is low, `rd_addr` holds stable.
- R13: `xfer_dir` carries the direction given with the buffer being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk at `base_addr` |
| base_addr | input | ADDR_W | Descriptor table base address |
| abort | input | 1 | Stop the walk and go idle |
| buf_valid | input | 1 | Device buffer offered |
| buf_ready | output | 1 | Walker accepts a buffer |
| buf_bytes | input | LEN_W | Bytes pending in the offered buffer |
| buf_dir | input | 1 | Direction of the offered buffer |
| rd_req_valid | output | 1 | Descriptor fetch request |
| rd_req_ready | input | 1 | Memory accepts the fetch |
| rd_addr | output | ADDR_W | Address of the descriptor to fetch |
| rd_rsp_valid | input | 1 | Descriptor word returned |
| rd_rsp_data | input | 64 | Descriptor word: address [31:0], size/flags [63:32] |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Transfer command accepted |
| xfer_addr | output | ADDR_W | Transfer start address |
| xfer_len | output | LEN_W | Transfer length in bytes |
| xfer_dir | output | 1 | Transfer direction |
| walk_active | output | 1 | A walk is in progress |
| buf_done | output | 1 | One-cycle pulse: buffer fully served |
| underrun | output | 1 | One-cycle pulse: table ended with bytes pending |
| tbl_end | output | 1 | Table has been exhausted |
| page_limit | output | 1 | Walk stopped by the one-page limit |

## Verification
The bench uses a descriptor with an odd size. A design that fails to clear bit 0 would issue odd lengths and shift every later address. It also uses a size of zero, which a wrong design would turn into an empty command rather than a 64 KiB one. Buffers are made to split a descriptor, and a design that refetched on each buffer would lose the leftover space and read the wrong table entries. A table of endless non-final entries checks that the walk stops after exactly 512 fetches with `page_limit` set, where a missing guard would keep reading memory. One test restarts while a fetch is in flight and swaps the table, so a design that accepted the stale response would issue a command at the wrong address.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BUF,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT_RSP,
    ST_ISSUE
  } walk_state_e;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
  parameter int LEN_W = 17
) (
  input  logic [31:0]      size_word,
  output logic [LEN_W-1:0] len,
  output logic             last
);
  localparam int FIELD_W = LEN_W - 1;

  logic [FIELD_W-1:0] field;

  // even byte count; an all-zero field stands for a full 2^FIELD_W span
  assign field = {size_word[FIELD_W-1:1], 1'b0};
  assign len   = (field == '0) ? (LEN_W'(1) << FIELD_W) : {1'b0, field};
  assign last  = size_word[31];
endmodule

// File: rtl/sgw_chunk.sv
module sgw_chunk #(
  parameter int W = 17
) (
  input  logic [W-1:0] want,
  input  logic [W-1:0] avail,
  output logic [W-1:0] size,
  output logic         want_done
);
  assign want_done = (want <= avail);
  assign size      = want_done ? want : avail;
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              abort,
  input  logic              buf_valid,
  output logic              buf_ready,
  input  logic [LEN_W-1:0]  buf_bytes,
  input  logic              buf_dir,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_dir,
  output logic              walk_active,
  output logic              buf_done,
  output logic              underrun,
  output logic              tbl_end,
  output logic              page_limit
);
  import sgw_pkg::*;

  localparam logic [ADDR_W-1:0] PAGE_SPAN = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PTR_STEP  = ADDR_W'(DESC_BYTES);

  walk_state_e       state;
  logic [ADDR_W-1:0] base_q, tbl_ptr, cur_addr;
  logic [LEN_W-1:0]  cur_len, pend;
  logic              cur_last, dir_q, rsp_owed;

  logic [LEN_W-1:0]  dec_len;
  logic              dec_last;
  logic [LEN_W-1:0]  chunk;
  logic              buf_finish;
  logic              page_hit;

  sgw_desc_decode #(.LEN_W(LEN_W)) u_dec (
    .size_word (rd_rsp_data[63:32]),
    .len       (dec_len),
    .last      (dec_last)
  );

  sgw_chunk #(.W(LEN_W)) u_chunk (
    .want      (pend),
    .avail     (cur_len),
    .size      (chunk),
    .want_done (buf_finish)
  );

  assign page_hit     = (tbl_ptr - base_q) >= PAGE_SPAN;
  assign buf_ready    = (state == ST_WAIT_BUF);
  assign rd_req_valid = (state == ST_FETCH) && !rsp_owed;
  assign rd_addr      = tbl_ptr;
  assign xfer_valid   = (state == ST_ISSUE);
  assign xfer_addr    = cur_addr;
  assign xfer_len     = chunk;
  assign xfer_dir     = dir_q;
  assign walk_active  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      tbl_ptr    <= '0;
      cur_addr   <= '0;
      cur_len    <= '0;
      cur_last   <= 1'b0;
      pend       <= '0;
      dir_q      <= 1'b0;
      rsp_owed   <= 1'b0;
      buf_done   <= 1'b0;
      underrun   <= 1'b0;
      tbl_end    <= 1'b0;
      page_limit <= 1'b0;
    end else begin
      buf_done <= 1'b0;
      underrun <= 1'b0;
      if (rd_rsp_valid)                 rsp_owed <= 1'b0;
      if (rd_req_valid && rd_req_ready) rsp_owed <= 1'b1;

      if (start) begin
        state      <= ST_WAIT_BUF;
        base_q     <= base_addr;
        tbl_ptr    <= base_addr;
        cur_addr   <= '0;
        cur_len    <= '0;
        cur_last   <= 1'b0;
        pend       <= '0;
        tbl_end    <= 1'b0;
        page_limit <= 1'b0;
      end else if (abort) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_WAIT_BUF: if (buf_valid) begin
            pend  <= buf_bytes;
            dir_q <= buf_dir;
            if (buf_bytes == '0) buf_done <= 1'b1;
            else                 state    <= ST_CHECK;
          end
          ST_CHECK: begin
            if (cur_len != '0) begin
              state <= ST_ISSUE;
            end else if (cur_last || page_hit) begin
              tbl_end    <= 1'b1;
              page_limit <= !cur_last;
              underrun   <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end
          ST_FETCH: if (rd_req_valid && rd_req_ready) begin
            tbl_ptr <= tbl_ptr + PTR_STEP;
            state   <= ST_WAIT_RSP;
          end
          ST_WAIT_RSP: if (rd_rsp_valid) begin
            cur_addr <= rd_rsp_data[ADDR_W-1:0];
            cur_len  <= dec_len;
            cur_last <= dec_last;
            state    <= ST_CHECK;
          end
          ST_ISSUE: if (xfer_ready) begin
            cur_addr <= cur_addr + ADDR_W'(chunk);
            cur_len  <= cur_len - chunk;
            pend     <= pend - chunk;
            if (buf_finish) begin
              buf_done <= 1'b1;
              state    <= ST_WAIT_BUF;
            end else begin
              state <= ST_CHECK;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sg_table_walker_chk.sv
module sg_table_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] base_addr,
  input logic              abort,
  input logic              buf_ready,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_dir,
  input logic              walk_active,
  input logic              buf_done,
  input logic              underrun
);
  logic [ADDR_W-1:0] base_c;

  always_ff @(posedge clk) begin
    if (rst)        base_c <= '0;
    else if (start) base_c <= base_addr;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !walk_active && !xfer_valid && !rd_req_valid);

  // R12
  xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready && !start && !abort |=>
      xfer_valid && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_dir));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready && !start && !abort |=> rd_req_valid && $stable(rd_addr));

  // R6
  one_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && rd_req_ready |=> !rd_req_valid);

  // R3
  even_len_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (xfer_len[0] == 1'b0) && (xfer_len != '0));

  // R9
  page_guard_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_addr - base_c) < ADDR_W'(PAGE_BYTES));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(buf_done && underrun));

  // R8
  buf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    buf_ready |-> !rd_req_valid && !xfer_valid);
endmodule

bind sg_table_walker sg_table_walker_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .abort(abort),
  .buf_ready(buf_ready), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_addr(rd_addr), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_dir(xfer_dir),
  .walk_active(walk_active), .buf_done(buf_done), .underrun(underrun)
);

// File: tb/sg_table_walker_tb.sv
module sg_table_walker_tb;
  localparam int AW = 32;
  localparam int LW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, abort = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic buf_valid = 1'b0, buf_dir = 1'b0;
  logic [LW-1:0] buf_bytes = '0;
  logic buf_ready, rd_req_valid, xfer_valid, xfer_dir;
  logic rd_req_ready = 1'b1, rd_rsp_valid = 1'b0, xfer_ready = 1'b1;
  logic [63:0] rd_rsp_data = '0;
  logic [AW-1:0] rd_addr, xfer_addr;
  logic [LW-1:0] xfer_len;
  logic walk_active, buf_done, underrun, tbl_end, page_limit;

  always #10 clk = ~clk;

  sg_table_walker #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(4096)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .abort(abort),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_bytes(buf_bytes), .buf_dir(buf_dir),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_dir(xfer_dir), .walk_active(walk_active),
    .buf_done(buf_done), .underrun(underrun), .tbl_end(tbl_end), .page_limit(page_limit)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mem_lo [16];
  logic [31:0] mem_hi [16];
  logic [31:0] mem_base = '0;
  logic stall = 1'b0, hold = 1'b0;

  int xfer_n = 0, fetch_n = 0, done_n = 0, under_n = 0;
  logic [31:0] rec_xaddr [1024];
  logic [31:0] rec_xlen  [1024];
  logic        rec_xdir  [1024];
  logic [31:0] rec_faddr [1024];
  logic        rsp_pend = 1'b0;
  logic [31:0] rsp_addr = '0;

  // memory responder, command sink and pulse counters, all on the falling edge
  always @(negedge clk) begin
    logic [31:0] idx;
    rd_rsp_valid = 1'b0;
    if (rsp_pend) begin
      idx = (rsp_addr - mem_base) >> 3;
      rd_rsp_data  = (idx < 16) ? {mem_hi[idx], mem_lo[idx]} : {32'h0000_0002, 32'h00A0_0000};
      rd_rsp_valid = 1'b1;
      rsp_pend     = 1'b0;
    end
    rd_req_ready = stall ? ~rd_req_ready : 1'b1;
    if (rd_req_valid && rd_req_ready) begin
      rsp_pend = 1'b1;
      rsp_addr = rd_addr;
      if (fetch_n < 1024) rec_faddr[fetch_n] = rd_addr;
      fetch_n++;
    end
    xfer_ready = hold ? 1'b0 : (stall ? ~xfer_ready : 1'b1);
    if (xfer_valid && xfer_ready) begin
      if (xfer_n < 1024) begin
        rec_xaddr[xfer_n] = xfer_addr;
        rec_xlen[xfer_n]  = 32'(xfer_len);
        rec_xdir[xfer_n]  = xfer_dir;
      end
      xfer_n++;
    end
    if (buf_done) done_n++;
    if (underrun) under_n++;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] b);
    @(negedge clk); start = 1'b1; base_addr = b;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_buf(input int bytes, input logic dir);
    @(negedge clk);
    buf_valid = 1'b1; buf_bytes = LW'(bytes); buf_dir = dir;
    while (!buf_ready) @(negedge clk);
    @(negedge clk);
    buf_valid = 1'b0;
  endtask

  task automatic wait_end();
    int d0, u0;
    d0 = done_n; u0 = under_n;
    while (done_n == d0 && under_n == u0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 walk_active", 32'(walk_active), 0);
    chk("R1 buf_ready", 32'(buf_ready), 0);
    chk("R1 rd_req_valid", 32'(rd_req_valid), 0);
    chk("R1 xfer_valid", 32'(xfer_valid), 0);
    chk("R1 tbl_end", 32'(tbl_end), 0);
  endtask

  task automatic t_single_last();
    int x0, f0, u0;
    mem_base = 32'h8000;
    mem_lo[0] = 32'h1000; mem_hi[0] = 32'h8000_0100;
    x0 = xfer_n; f0 = fetch_n;
    do_start(32'h8000);
    send_buf(32'h100, 1'b1);
    wait_end();
    chk("R2 first fetch addr", rec_faddr[f0], 32'h8000);
    chk("R7 xfer addr", rec_xaddr[x0], 32'h1000);
    chk("R7 xfer len", rec_xlen[x0], 32'h100);
    chk("R13 dir", 32'(rec_xdir[x0]), 1);
    chk("R8 buf_ready again", 32'(buf_ready), 1);
    u0 = under_n;
    send_buf(32'h10, 1'b1);
    wait_end();
    chk("R5 no fetch after last", 32'(fetch_n - f0), 1);
    chk("R10 underrun pulse", 32'(under_n - u0), 1);
    chk("R5 tbl_end", 32'(tbl_end), 1);
    chk("R5 page_limit clear", 32'(page_limit), 0);
    chk("R10 idle", 32'(walk_active), 0);
    chk("R5 no extra xfer", 32'(xfer_n - x0), 1);
  endtask

  task automatic t_split_odd();
    int x0, f0, d0;
    stall = 1'b1;
    mem_base = 32'h6000;
    mem_lo[0] = 32'h2000; mem_hi[0] = 32'h0000_0105;
    mem_lo[1] = 32'h9000; mem_hi[1] = 32'h8000_0100;
    x0 = xfer_n; f0 = fetch_n; d0 = done_n;
    do_start(32'h6000);
    send_buf(32'h80, 1'b0);
    wait_end();
    send_buf(32'h184, 1'b0);
    wait_end();
    chk("R7 xfer count", 32'(xfer_n - x0), 3);
    chk("R7 x0 addr", rec_xaddr[x0], 32'h2000);
    chk("R3 x0 len", rec_xlen[x0], 32'h80);
    chk("R7 x1 addr carry", rec_xaddr[x0+1], 32'h2080);
    chk("R3 x1 len odd masked", rec_xlen[x0+1], 32'h84);
    chk("R7 x2 addr", rec_xaddr[x0+2], 32'h9000);
    chk("R7 x2 len", rec_xlen[x0+2], 32'h100);
    chk("R13 dir", 32'(rec_xdir[x0+2]), 0);
    chk("R6 fetch count", 32'(fetch_n - f0), 2);
    chk("R2 second fetch addr", rec_faddr[f0+1], 32'h6008);
    chk("R8 done pulses", 32'(done_n - d0), 2);
    stall = 1'b0;
  endtask

  task automatic t_zero_len();
    int x0, d0;
    mem_base = 32'h7000;
    mem_lo[0] = 32'h0004_0000; mem_hi[0] = 32'h8000_0000;
    x0 = xfer_n; d0 = done_n;
    do_start(32'h7000);
    send_buf(32'h0, 1'b0);
    @(negedge clk);
    chk("R8 zero-byte buffer done", 32'(done_n - d0), 1);
    send_buf(32'h10000, 1'b0);
    wait_end();
    chk("R4 len 64K", rec_xlen[x0], 32'h10000);
    chk("R4 addr", rec_xaddr[x0], 32'h0004_0000);
    chk("R4 one xfer", 32'(xfer_n - x0), 1);
  endtask

  task automatic t_page();
    int x0, f0, u0;
    mem_base = 32'h0010_0000;
    for (int i = 0; i < 16; i++) begin
      mem_lo[i] = 32'h00A0_0000; mem_hi[i] = 32'h0000_0002;
    end
    x0 = xfer_n; f0 = fetch_n; u0 = under_n;
    do_start(32'h0010_0000);
    send_buf(32'h10000, 1'b0);
    wait_end();
    chk("R9 fetch count", 32'(fetch_n - f0), 512);
    chk("R9 last fetch addr", rec_faddr[f0+511], 32'h0010_0FF8);
    chk("R9 xfer count", 32'(xfer_n - x0), 512);
    chk("R9 page_limit", 32'(page_limit), 1);
    chk("R9 tbl_end", 32'(tbl_end), 1);
    chk("R10 underrun", 32'(under_n - u0), 1);
  endtask

  task automatic t_reset_mid();
    hold = 1'b1;
    mem_base = 32'h3000;
    mem_lo[0] = 32'h5000; mem_hi[0] = 32'h8000_0040;
    do_start(32'h3000);
    send_buf(32'h40, 1'b0);
    while (!xfer_valid) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid reset xfer_valid", 32'(xfer_valid), 0);
    chk("R1 mid reset active", 32'(walk_active), 0);
    chk("R1 mid reset page_limit", 32'(page_limit), 0);
    hold = 1'b0;
  endtask

  task automatic t_abort_restart();
    int x0, f0;
    hold = 1'b1;
    mem_base = 32'h3000;
    mem_lo[0] = 32'h5000; mem_hi[0] = 32'h8000_0040;
    x0 = xfer_n;
    do_start(32'h3000);
    send_buf(32'h40, 1'b0);
    while (!xfer_valid) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R11 abort drops xfer", 32'(xfer_valid), 0);
    chk("R11 abort idle", 32'(walk_active), 0);
    chk("R11 nothing accepted", 32'(xfer_n - x0), 0);
    hold = 1'b0;
    // restart: descriptor state cleared, so a fresh fetch at the base
    f0 = fetch_n;
    do_start(32'h3000);
    send_buf(32'h40, 1'b0);
    for (int i = 0; i < 20 && fetch_n == f0; i++) @(negedge clk);
    chk("R11 restart refetches", 32'(fetch_n - f0), 1);
    // restart again while that fetch is in flight, on a new table
    mem_base = 32'h3800;
    start = 1'b1; base_addr = 32'h3800;
    @(negedge clk);
    start = 1'b0;
    x0 = xfer_n;
    send_buf(32'h40, 1'b1);
    wait_end();
    chk("R11 stale response dropped addr", rec_xaddr[x0], 32'h5000);
    chk("R11 new table len", rec_xlen[x0], 32'h40);
    chk("R11 new base fetch", rec_faddr[fetch_n-1], 32'h3800);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single_last();
        t_split_odd();
        t_zero_len();
        t_page();
        t_reset_mid();
        t_abort_restart();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule